// File: doc/BRIEF.md
# Cascaded Priority Interrupt Vector Array

This block arbitrates sixteen interrupt request lines for an 8-bit processor. The lines are split into two eight-level priority units. The units are linked by an enable chain: the unit holding levels 8 to 15 sits first in the chain, and while it has any request active it holds the enable to the unit holding levels 0 to 7 low. When an enabled request is present and the block is armed, a single interrupt line is raised to the processor.

Every acknowledge is answered with the same one-byte restart opcode, 0xFF, whichever level won. At the rising edge of the acknowledge strobe the block records the winning level as an offset byte. The service routine reads this byte later through an input port. It uses the byte as the low half of an indirect jump address, so each level gets an eight-byte slot for its entry code.

The offset byte has three fields. The upper two bits form a one-hot group pair. The next three bits hold the inverted position within the group. The lowest three bits are always zero. The number of units, the levels per unit, the data width and the acknowledge opcode are all parameters.

Top module: `irq_vector_array`

## Requirements
- R1: Among active enabled requests, the highest-numbered level wins: level 15 has the highest priority and level 0 the lowest.
- R2: The unit for levels 8-15 is first in the enable chain. `chain_en_out` is high only when `chain_en_in` is high and no request line is active. Any active request in levels 8-15 keeps levels 0-7 from winning.
- R3: `irq` is high while the block is armed, `chain_en_in` is high and at least one request line is active.
- R4: While `inta` is high, `data_out` carries 0xFF and `data_oe` is high, regardless of the winning level.
- R5: Bits 2:0 of every captured offset byte are zero.
- R6: Bit 7 of the offset byte is 1 for a level in 8-15 and 0 for a level in 0-7. Bit 6 is always the complement of bit 7.
- R7: Bits 5:3 of the offset byte are the bitwise inverse of the level's position (level mod 8). Level 0 yields 0x78, level 5 yields 0x50, level 8 yields 0xB8 and level 15 yields 0x80.
- R8: The offset byte is captured at the first clock edge with `inta` high after it was low. Later changes of the request lines do not alter what a port read returns until the next acknowledge.
- R9: One clock edge after `inta` is seen, `irq` is low. It stays low until a request line rises (low in one cycle, high in the next), or until no enabled request is active. It comes back on the edge after that event.
- R10: A port read returns 0x00 after reset with no acknowledge yet, and after an acknowledge at which no enabled request was active.
- R11: With both `inta` and `port_rd` low, `data_oe` is low and `data_out` is 0x00.
- R12: When `inta` and `port_rd` are high together, the acknowledge opcode 0xFF is driven.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req | input | 16 | Interrupt request lines, bit n is level n |
| chain_en_in | input | 1 | Enable into the head of the priority chain |
| inta | input | 1 | Interrupt acknowledge strobe from the CPU |
| port_rd | input | 1 | Offset port read strobe from the CPU |
| irq | output | 1 | Interrupt request to the CPU |
| data_out | output | 8 | Data bus value (opcode or offset byte) |
| data_oe | output | 1 | Data bus drive enable |
| chain_en_out | output | 1 | Enable passed on to a following lower-priority array |

## Verification
The bench builds the block with its default parameters: two units of eight levels, an 8-bit bus and a 0xFF opcode. With these values both ends of the offset table (0x78 and 0x80) can be reached, and so can both sides of the group boundary (levels 7 and 8). Requests can be spread across both units so that the upper unit's enable ripple is seen to mask the lower one. The acknowledge-then-read sequence is also run with requests changed or withdrawn between the strobes, which exercises capture hold, re-arming and the empty read.

// File: rtl/irq_prio_pkg.sv
// Package: shared defaults for the cascaded interrupt vector array.
// Assumes: one offset group bit per unit, offset fits the data bus.
package irq_prio_pkg;
    localparam int DEF_UNITS      = 2;
    localparam int DEF_LEVELS     = 8;
    localparam int DEF_DATA_W     = 8;
    localparam logic [7:0] DEF_ACK_OPCODE = 8'hFF;
endpackage

// File: rtl/irq_prio_unit.sv
// Module: one priority unit of the chain.
// What it does: it finds the highest-numbered active request in its group.
// It reports a hit only when its chain enable is high, and it passes the
// enable on only when none of its requests is active.
// Assumes: LEVELS is a power of two.
module irq_prio_unit #(
    parameter int LEVELS = 8,
    localparam int CODE_W = $clog2(LEVELS)
) (
    input  logic [LEVELS-1:0] req,
    input  logic              en_in,
    output logic              hit,
    output logic [CODE_W-1:0] pos,
    output logic              en_out
);
    logic any_req;

    // Highest-index scan: later set bits override earlier ones.
    always_comb begin
        pos = '0;
        for (int i = 0; i < LEVELS; i++) begin
            if (req[i]) pos = i[CODE_W-1:0];
        end
    end

    // Hit and enable ripple toward the lower-priority neighbour.
    always_comb begin
        any_req = |req;
        hit     = en_in & any_req;
        en_out  = en_in & ~any_req;
    end
endmodule

// File: rtl/irq_offset_enc.sv
// Module: builds the offset byte from the per-unit results.
// What it does: the group field is one-hot (bit g set for group g, and the
// highest group sits in the top bit), the code field is the inverted
// position, and the low bits are zero.
// Assumes: at most one hit is set, which the enable chain guarantees.
module irq_offset_enc #(
    parameter int UNITS  = 2,
    parameter int LEVELS = 8,
    parameter int DATA_W = 8,
    localparam int CODE_W = $clog2(LEVELS),
    localparam int ZERO_W = DATA_W - UNITS - CODE_W
) (
    input  logic [UNITS-1:0]        grp_hit,
    input  logic [UNITS*CODE_W-1:0] grp_pos,
    output logic                    any_hit,
    output logic [DATA_W-1:0]       offset
);
    // OR together the field of each group; only the winning group contributes.
    always_comb begin
        offset  = '0;
        any_hit = |grp_hit;
        for (int g = 0; g < UNITS; g++) begin
            if (grp_hit[g]) begin
                offset[DATA_W-UNITS+g] = 1'b1;
                offset[ZERO_W +: CODE_W] = ~grp_pos[g*CODE_W +: CODE_W];
            end
        end
    end
endmodule

// File: rtl/irq_vector_array.sv
// Module: top of the cascaded priority interrupt vector array.
// What it does: it chains UNITS priority units, highest group first. It
// raises irq for an enabled request while armed. It answers acknowledge
// with a fixed opcode, captures the offset byte on the rising edge of
// acknowledge, and returns that byte on a port read.
// Assumes: strobes are synchronous to clk. DATA_W >= UNITS + log2(LEVELS).
module irq_vector_array
    import irq_prio_pkg::*;
#(
    parameter int UNITS  = DEF_UNITS,
    parameter int LEVELS = DEF_LEVELS,
    parameter int DATA_W = DEF_DATA_W,
    parameter logic [DATA_W-1:0] ACK_OPCODE = DEF_ACK_OPCODE,
    localparam int CODE_W = $clog2(LEVELS),
    localparam int NREQ   = UNITS * LEVELS,
    localparam int ZERO_W = DATA_W - UNITS - CODE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NREQ-1:0]   req,
    input  logic              chain_en_in,
    input  logic              inta,
    input  logic              port_rd,
    output logic              irq,
    output logic [DATA_W-1:0] data_out,
    output logic              data_oe,
    output logic              chain_en_out
);
    logic [UNITS:0]          en_chain;
    logic [UNITS-1:0]        grp_hit;
    logic [UNITS*CODE_W-1:0] grp_pos;
    logic                    any_hit;
    logic [DATA_W-1:0]       offset;
    logic [NREQ-1:0]         req_q;
    logic                    inta_q, armed_q, cap_valid_q;
    logic [DATA_W-1:0]       cap_q;
    logic                    new_req;

    assign en_chain[0] = chain_en_in;

    // Chain stage k serves group UNITS-1-k, so the highest group comes first.
    for (genvar k = 0; k < UNITS; k++) begin : g_unit
        localparam int G = UNITS - 1 - k;
        irq_prio_unit #(.LEVELS(LEVELS)) i_unit (
            .req    (req[G*LEVELS +: LEVELS]),
            .en_in  (en_chain[k]),
            .hit    (grp_hit[G]),
            .pos    (grp_pos[G*CODE_W +: CODE_W]),
            .en_out (en_chain[k+1])
        );
    end

    assign chain_en_out = en_chain[UNITS];

    irq_offset_enc #(.UNITS(UNITS), .LEVELS(LEVELS), .DATA_W(DATA_W)) i_enc (
        .grp_hit (grp_hit),
        .grp_pos (grp_pos),
        .any_hit (any_hit),
        .offset  (offset)
    );

    // A request line that was low last cycle and is high now.
    assign new_req = |(req & ~req_q);

    // Previous request and strobe values, used for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q  <= '0;
            inta_q <= 1'b0;
        end else begin
            req_q  <= req;
            inta_q <= inta;
        end
    end

    // Arm state: cleared by acknowledge, set by a fresh request or by idle.
    always_ff @(posedge clk) begin
        if (!rst_n)                      armed_q <= 1'b1;
        else if (inta)                   armed_q <= 1'b0;
        else if (new_req || !any_hit)    armed_q <= 1'b1;
    end

    // Offset capture on the rising edge of acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_q       <= '0;
            cap_valid_q <= 1'b0;
        end else if (inta && !inta_q) begin
            cap_q       <= offset;
            cap_valid_q <= any_hit;
        end
    end

    // Interrupt request to the CPU.
    assign irq = armed_q & any_hit;

    // Bus drive: the acknowledge opcode takes precedence over the port read.
    always_comb begin
        data_oe  = inta | port_rd;
        data_out = '0;
        if (inta)                        data_out = ACK_OPCODE;
        else if (port_rd && cap_valid_q) data_out = cap_q;
    end

    // R4 R12
    ack_opcode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        inta |-> (data_out == ACK_OPCODE && data_oe));
    // R9
    ack_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        inta |=> !irq);
    // R8
    cap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(inta && !inta_q) |=> $stable(cap_q) && $stable(cap_valid_q));
    // R5
    cap_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cap_valid_q |-> cap_q[ZERO_W-1:0] == '0);
    // R6
    cap_group_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cap_valid_q |-> $countones(cap_q[DATA_W-1 -: UNITS]) == 1);
    // R2
    chain_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !chain_en_in |-> (!chain_en_out && !irq));
    // R2
    one_winner_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grp_hit));
    // R10
    empty_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (port_rd && !inta && !cap_valid_q) |-> data_out == '0);
endmodule

// File: tb/test_irq_vector_array.sv
module test_irq_vector_array;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] req = '0;
    logic        chain_en_in = 1'b1;
    logic        inta = 1'b0;
    logic        port_rd = 1'b0;
    logic        irq, data_oe, chain_en_out;
    logic [7:0]  data_out;
    int          n_run = 0, n_fail = 0;

    always #10 clk = ~clk;

    irq_vector_array i_irq_vector_array (
        .clk(clk), .rst_n(rst_n), .req(req), .chain_en_in(chain_en_in),
        .inta(inta), .port_rd(port_rd), .irq(irq), .data_out(data_out),
        .data_oe(data_oe), .chain_en_out(chain_en_out)
    );

    function automatic logic [7:0] exp_off(int lvl);
        logic [2:0] p = lvl[2:0];
        return {lvl >= 8, lvl < 8, ~p, 3'b000};
    endfunction

    task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic step(int n = 1);
        repeat (n) begin @(posedge clk); @(negedge clk); end
    endtask

    // Acknowledge, check the opcode, then read the port and check the offset.
    task automatic ack_read(string tag, logic [7:0] exp);
        inta = 1'b1; #1;
        chk({tag, " R4 opcode"}, data_out, 8'hFF);
        chk({tag, " R4 oe"}, {7'd0, data_oe}, 8'd1);
        step();
        inta = 1'b0; port_rd = 1'b1; #1;
        chk({tag, " offset"}, data_out, exp);
        step();
        port_rd = 1'b0;
    endtask

    task automatic idle();
        req = '0; step(2);
    endtask

    task automatic t_reset();
        #1;
        chk("R3 reset irq", {7'd0, irq}, 8'd0);
        chk("R11 reset oe", {7'd0, data_oe}, 8'd0);
        chk("R11 reset bus", data_out, 8'h00);
        chk("R2 idle chain out", {7'd0, chain_en_out}, 8'd1);
        port_rd = 1'b1; #1;
        chk("R10 read after reset", data_out, 8'h00);
        step(); port_rd = 1'b0;
    endtask

    task automatic t_single();
        int lv[5] = '{0, 5, 7, 8, 15};
        foreach (lv[i]) begin
            req = 16'd1 << lv[i]; #1;
            chk($sformatf("R3 irq level %0d", lv[i]), {7'd0, irq}, 8'd1);
            ack_read($sformatf("R7 R5 R6 level %0d", lv[i]), exp_off(lv[i]));
            idle();
        end
    endtask

    task automatic t_priority();
        req = (16'd1 << 3) | (16'd1 << 9) | (16'd1 << 12); #1;
        chk("R2 chain out busy", {7'd0, chain_en_out}, 8'd0);
        ack_read("R1 pick 12", exp_off(12));
        idle();
        req = 16'h0041; #1;
        ack_read("R1 pick 6", exp_off(6));
        idle();
        req = 16'h0180; #1;
        ack_read("R2 upper masks lower", exp_off(8));
        idle();
    endtask

    task automatic t_chain();
        chain_en_in = 1'b0; req = 16'h8001; #1;
        chk("R2 disabled irq", {7'd0, irq}, 8'd0);
        chk("R2 disabled chain out", {7'd0, chain_en_out}, 8'd0);
        ack_read("R10 ack with none enabled", 8'h00);
        chain_en_in = 1'b1;
        idle();
    endtask

    task automatic t_hold();
        req = 16'd1 << 10; #1;
        inta = 1'b1; step(); inta = 1'b0;
        req = 16'd1 << 2; step();
        port_rd = 1'b1; #1;
        chk("R8 held capture", data_out, exp_off(10));
        step(); port_rd = 1'b0;
        idle();
    endtask

    task automatic t_rearm();
        req = 16'd1 << 4; #1;
        inta = 1'b1; step(); inta = 1'b0; #1;
        chk("R9 low after ack", {7'd0, irq}, 8'd0);
        step(3);
        chk("R9 stays low with same request", {7'd0, irq}, 8'd0);
        req = req | (16'd1 << 1); #1;
        chk("R9 not yet back", {7'd0, irq}, 8'd0);
        step();
        chk("R9 back after new request", {7'd0, irq}, 8'd1);
        idle();
    endtask

    task automatic t_strobes();
        req = 16'd1 << 13; #1;
        inta = 1'b1; port_rd = 1'b1; #1;
        chk("R12 both strobes", data_out, 8'hFF);
        step(); inta = 1'b0; port_rd = 1'b0; #1;
        chk("R11 no strobe oe", {7'd0, data_oe}, 8'd0);
        chk("R11 no strobe bus", data_out, 8'h00);
        port_rd = 1'b1; #1;
        chk("R7 level 13 read", data_out, exp_off(13));
        step(); port_rd = 1'b0;
        idle();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        @(negedge clk); step(2);
        rst_n = 1'b1;
        t_reset();
        t_single();
        t_priority();
        t_chain();
        t_hold();
        t_rearm();
        t_strobes();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule